// File: doc/BRIEF.md
# Triangle Tile Setup Engine

This block prepares one triangle for a purely additive per-pixel rasterizer that works on square 16x16 screen tiles. A host presents three screen-space vertices (integer x and y, signed fixed-point depth with 8 fractional bits), an 8-bit color and the index of the tile being drawn. The block returns everything the pixel stage needs so that it only adds from there on. That is the value of each of the three edge functions at the tile's top-left pixel, with their step per pixel in x and in y. It also returns the depth at that pixel and the two depth slopes.

All products go through one iterative shift-add multiplier, and both quotients go through one restoring divider that yields one quotient bit per cycle. The setup is repeated for every tile a triangle touches, so the host sends the same triangle again with a new tile index. A triangle of zero area is reported as degenerate. The pixel stage then draws nothing for it.

Top module: `tri_setup`

## Requirements
- R1: After reset `in_ready` is high. A triangle is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low from the next cycle through the cycle in which `out_valid` is high, and it is high again in the cycle after that.
- R2: For every accepted triangle, `out_valid` is high for exactly one cycle, and all result ports are valid in that cycle.
- R3: With tile origin tx = 16*tile_x and ty = 16*tile_y, edge i runs from vertex i to vertex (i+1) mod 3. `out_edge[i]` = (tx-xi)(yj-yi) - (ty-yi)(xj-xi) as a 32-bit signed value, where j = (i+1) mod 3.
- R4: `out_dedx[i]` = yj-yi and `out_dedy[i]` = xi-xj (12-bit signed), with j = (i+1) mod 3.
- R5: The doubled signed area is A = (x1-x0)(y2-y0) - (x2-x0)(y1-y0). `out_degen` is 1 exactly when A = 0.
- R6: For A != 0, `out_dzdx` = ((z1-z0)(y2-y0) - (z2-z0)(y1-y0)) / A and `out_dzdy` = ((z2-z0)(x1-x0) - (z1-z0)(x2-x0)) / A. Each quotient is truncated toward zero and carries 8 fractional bits, like z.
- R7: `out_z` = z0 + dzdx*(tx-x0) + dzdy*(ty-y0), using the truncated slopes of R6 and taken modulo 2^32.
- R8: For a degenerate triangle the divider is not used, both slopes are 0 and `out_z` equals z0 sign-extended.
- R9: Vertex, color and tile inputs are sampled only at acceptance. Changes to them while busy do not alter the result. `out_color` returns the accepted color.
- R10: While `rst_n` is low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Triangle and tile offered |
| in_ready | output | 1 | Engine idle, will accept |
| vx | input | 3x10 | Vertex x coordinates, vertex 0 in the low slot |
| vy | input | 3x9 | Vertex y coordinates |
| vz | input | 3x16 | Vertex depth, signed, 8 fractional bits |
| color | input | 8 | Triangle color |
| tile_x | input | 6 | Tile column index |
| tile_y | input | 5 | Tile row index |
| out_valid | output | 1 | One-cycle result strobe |
| out_edge | output | 3x32 | Edge function values at the tile origin |
| out_dedx | output | 3x12 | Edge step per pixel in x |
| out_dedy | output | 3x12 | Edge step per pixel in y |
| out_z | output | 32 | Depth at the tile origin, 8 fractional bits |
| out_dzdx | output | 32 | Depth slope in x, 8 fractional bits |
| out_dzdy | output | 32 | Depth slope in y, 8 fractional bits |
| out_color | output | 8 | Accepted color |
| out_degen | output | 1 | Zero-area triangle |

## Verification
The hardest case to reach from the ports is the path in which the divider is skipped. It needs a triangle whose doubled area is exactly zero. Random vertices almost never produce one, so the stimulus builds collinear and coincident vertex sets on purpose and places them on several tiles. Sign handling in both iterative units is the other subtle area. The sweep uses both windings, negative depths and tiles on either side of each vertex, so that every operand sign combination reaches the multiplier and the divider. After each acceptance the inputs are overwritten with unrelated values to show that the result comes only from the captured copy.

// File: rtl/tri_setup_pkg.sv
package tri_setup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_DIV,
    ST_DONE
  } seq_state_t;

  localparam int STEP_W     = 4;
  // step numbers whose end changes the flow of the sequencer
  localparam int STEP_NZY   = 11;
  localparam int STEP_DZDX  = 12;
  localparam int STEP_DZDY  = 13;
  localparam int STEP_ZX    = 14;
  localparam int STEP_LAST  = 15;

endpackage

// File: rtl/tri_setup_mul.sv
// Iterative signed multiplier: one bit of the b magnitude per cycle.
module tri_setup_mul #(
  parameter int AW = 32,
  parameter int BW = 12,
  localparam int PW = AW + BW,
  localparam int CNW = $clog2(BW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [AW-1:0] a,
  input  logic signed [BW-1:0] b,
  output logic                 busy,
  output logic                 done,
  output logic signed [PW-1:0] prod
);

  logic [PW-1:0]  mcand;
  logic [BW-1:0]  mplier;
  logic [PW-1:0]  acc;
  logic           neg;
  logic [CNW-1:0] cnt;

  function automatic logic [AW-1:0] mag_a(input logic signed [AW-1:0] v);
    return v[AW-1] ? AW'(-v) : AW'(v);
  endfunction

  function automatic logic [BW-1:0] mag_b(input logic signed [BW-1:0] v);
    return v[BW-1] ? BW'(-v) : BW'(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand  <= '0;
      mplier <= '0;
      acc    <= '0;
      neg    <= 1'b0;
      cnt    <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        mcand  <= PW'(mag_a(a));
        mplier <= mag_b(b);
        acc    <= '0;
        neg    <= a[AW-1] ^ b[BW-1];
        cnt    <= CNW'(BW);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign prod = neg ? -$signed(acc) : $signed(acc);

endmodule

// File: rtl/tri_setup_div.sv
// Restoring signed divider, one quotient bit per cycle, truncates toward zero.
module tri_setup_div #(
  parameter int NW = 32,
  localparam int CNW = $clog2(NW + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [NW-1:0] num,
  input  logic signed [NW-1:0] den,
  output logic                 busy,
  output logic                 done,
  output logic signed [NW-1:0] quo
);

  logic [NW:0]    rem;
  logic [NW-1:0]  qsh;
  logic [NW-1:0]  dmag;
  logic           neg;
  logic [CNW-1:0] cnt;
  logic [NW:0]    trial;
  logic           fits;

  function automatic logic [NW-1:0] mag(input logic signed [NW-1:0] v);
    return v[NW-1] ? NW'(-v) : NW'(v);
  endfunction

  always_comb begin
    trial = {rem[NW-1:0], qsh[NW-1]};
    fits  = trial >= {1'b0, dmag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      qsh  <= '0;
      dmag <= '0;
      neg  <= 1'b0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        qsh  <= mag(num);
        dmag <= mag(den);
        neg  <= num[NW-1] ^ den[NW-1];
        cnt  <= CNW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? trial - {1'b0, dmag} : trial;
        qsh  <= {qsh[NW-2:0], fits};
        cnt  <= cnt - 1'b1;
        if (cnt == CNW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quo = neg ? -$signed(qsh) : $signed(qsh);

endmodule

// File: rtl/tri_setup.sv
module tri_setup
  import tri_setup_pkg::*;
#(
  parameter int XW      = 10,
  parameter int YW      = 9,
  parameter int ZW      = 16,
  parameter int TXW     = 6,
  parameter int TYW     = 5,
  parameter int TILE_LG = 4,
  parameter int RW      = 32,
  parameter int COLW    = 8,
  localparam int CW     = ((XW > YW) ? XW : YW) + 1,
  localparam int CDW    = CW + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [2:0][XW-1:0]        vx,
  input  logic [2:0][YW-1:0]        vy,
  input  logic [2:0][ZW-1:0]        vz,
  input  logic [COLW-1:0]           color,
  input  logic [TXW-1:0]            tile_x,
  input  logic [TYW-1:0]            tile_y,
  output logic                      out_valid,
  output logic [2:0][RW-1:0]        out_edge,
  output logic [2:0][CDW-1:0]       out_dedx,
  output logic [2:0][CDW-1:0]       out_dedy,
  output logic signed [RW-1:0]      out_z,
  output logic signed [RW-1:0]      out_dzdx,
  output logic signed [RW-1:0]      out_dzdy,
  output logic [COLW-1:0]           out_color,
  output logic                      out_degen
);

  localparam int PW = RW + CDW;

  // ---------------- arithmetic helpers ----------------
  function automatic logic signed [CDW-1:0] cdiff(input logic [CW-1:0] p, input logic [CW-1:0] q);
    return $signed({1'b0, p}) - $signed({1'b0, q});
  endfunction

  function automatic logic signed [RW-1:0] widen(input logic signed [CDW-1:0] v);
    return {{(RW-CDW){v[CDW-1]}}, v};
  endfunction

  function automatic logic signed [RW-1:0] zext_s(input logic [ZW-1:0] v);
    return {{(RW-ZW){v[ZW-1]}}, v};
  endfunction

  function automatic logic signed [RW-1:0] zdiff(input logic [ZW-1:0] p, input logic [ZW-1:0] q);
    return zext_s(p) - zext_s(q);
  endfunction

  // ---------------- state ----------------
  seq_state_t             state;
  logic [STEP_W-1:0]      step;
  logic                   kick;
  logic [2:0][CW-1:0]     cx, cy;
  logic [2:0][ZW-1:0]     cz;
  logic [CW-1:0]          ctx, cty;
  logic [COLW-1:0]        ccol;
  logic signed [RW-1:0]   acc;
  logic signed [RW-1:0]   edge_r [3];
  logic signed [RW-1:0]   area, nzx, nzy, dzdx, dzdy, zorg;

  // internal events, named for the checker
  logic                   mul_start, mul_busy, mul_done;
  logic                   div_start, div_busy, div_done;
  logic signed [RW-1:0]   op_a;
  logic signed [CDW-1:0]  op_b;
  logic signed [PW-1:0]   mul_prod;
  logic signed [RW-1:0]   prod_lo;
  logic signed [RW-1:0]   div_num;
  logic signed [RW-1:0]   div_quo;

  assign mul_start = kick && (state == ST_MUL);
  assign div_start = kick && (state == ST_DIV);
  assign prod_lo   = mul_prod[RW-1:0];
  assign div_num   = (step == STEP_W'(STEP_DZDX)) ? nzx : nzy;

  // operand schedule for the shared multiplier
  always_comb begin
    op_a = '0;
    op_b = '0;
    case (step)
      4'd0:  begin op_a = widen(cdiff(ctx, cx[0]));  op_b = cdiff(cy[1], cy[0]); end
      4'd1:  begin op_a = widen(cdiff(cty, cy[0]));  op_b = cdiff(cx[1], cx[0]); end
      4'd2:  begin op_a = widen(cdiff(ctx, cx[1]));  op_b = cdiff(cy[2], cy[1]); end
      4'd3:  begin op_a = widen(cdiff(cty, cy[1]));  op_b = cdiff(cx[2], cx[1]); end
      4'd4:  begin op_a = widen(cdiff(ctx, cx[2]));  op_b = cdiff(cy[0], cy[2]); end
      4'd5:  begin op_a = widen(cdiff(cty, cy[2]));  op_b = cdiff(cx[0], cx[2]); end
      4'd6:  begin op_a = widen(cdiff(cx[1], cx[0])); op_b = cdiff(cy[2], cy[0]); end
      4'd7:  begin op_a = widen(cdiff(cx[2], cx[0])); op_b = cdiff(cy[1], cy[0]); end
      4'd8:  begin op_a = zdiff(cz[1], cz[0]);        op_b = cdiff(cy[2], cy[0]); end
      4'd9:  begin op_a = zdiff(cz[2], cz[0]);        op_b = cdiff(cy[1], cy[0]); end
      4'd10: begin op_a = zdiff(cz[2], cz[0]);        op_b = cdiff(cx[1], cx[0]); end
      4'd11: begin op_a = zdiff(cz[1], cz[0]);        op_b = cdiff(cx[2], cx[0]); end
      4'd14: begin op_a = dzdx;                       op_b = cdiff(ctx, cx[0]);   end
      4'd15: begin op_a = dzdy;                       op_b = cdiff(cty, cy[0]);   end
      default: ;
    endcase
  end

  tri_setup_mul #(.AW(RW), .BW(CDW)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .a     (op_a),
    .b     (op_b),
    .busy  (mul_busy),
    .done  (mul_done),
    .prod  (mul_prod)
  );

  tri_setup_div #(.NW(RW)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (div_num),
    .den   (area),
    .busy  (div_busy),
    .done  (div_done),
    .quo   (div_quo)
  );

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      kick  <= 1'b0;
      cx    <= '0;
      cy    <= '0;
      cz    <= '0;
      ctx   <= '0;
      cty   <= '0;
      ccol  <= '0;
      acc   <= '0;
      for (int i = 0; i < 3; i++) edge_r[i] <= '0;
      area  <= '0;
      nzx   <= '0;
      nzy   <= '0;
      dzdx  <= '0;
      dzdy  <= '0;
      zorg  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            for (int i = 0; i < 3; i++) begin
              cx[i] <= CW'(vx[i]);
              cy[i] <= CW'(vy[i]);
              cz[i] <= vz[i];
            end
            ctx   <= CW'({tile_x, {TILE_LG{1'b0}}});
            cty   <= CW'({tile_y, {TILE_LG{1'b0}}});
            ccol  <= color;
            step  <= '0;
            kick  <= 1'b1;
            state <= ST_MUL;
          end
        end
        ST_MUL: begin
          kick <= 1'b0;
          if (mul_done) begin
            case (step)
              4'd1:  edge_r[0] <= acc - prod_lo;
              4'd3:  edge_r[1] <= acc - prod_lo;
              4'd5:  edge_r[2] <= acc - prod_lo;
              4'd7:  area      <= acc - prod_lo;
              4'd9:  nzx       <= acc - prod_lo;
              4'd11: nzy       <= acc - prod_lo;
              4'd15: zorg      <= zext_s(cz[0]) + acc + prod_lo;
              default: acc     <= prod_lo;
            endcase
            if (step == STEP_W'(STEP_LAST)) begin
              state <= ST_DONE;
            end else if (step == STEP_W'(STEP_NZY)) begin
              kick <= 1'b1;
              if (area == '0) begin
                dzdx <= '0;
                dzdy <= '0;
                step <= STEP_W'(STEP_ZX);
              end else begin
                step  <= STEP_W'(STEP_DZDX);
                state <= ST_DIV;
              end
            end else begin
              step <= step + 1'b1;
              kick <= 1'b1;
            end
          end
        end
        ST_DIV: begin
          kick <= 1'b0;
          if (div_done) begin
            kick <= 1'b1;
            if (step == STEP_W'(STEP_DZDX)) begin
              dzdx <= div_quo;
              step <= STEP_W'(STEP_DZDY);
            end else begin
              dzdy  <= div_quo;
              step  <= STEP_W'(STEP_ZX);
              state <= ST_MUL;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- outputs ----------------
  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_DONE);
  assign out_z     = zorg;
  assign out_dzdx  = dzdx;
  assign out_dzdy  = dzdy;
  assign out_color = ccol;
  assign out_degen = (area == '0);

  for (genvar g = 0; g < 3; g++) begin : g_edge
    localparam int NX = (g + 1) % 3;
    assign out_edge[g] = edge_r[g];
    assign out_dedx[g] = cdiff(cy[NX], cy[g]);
    assign out_dedy[g] = cdiff(cx[g], cx[NX]);
  end

endmodule

// File: rtl/tri_setup_chk.sv
module tri_setup_chk #(
  parameter int RW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_degen,
  input logic signed [RW-1:0] out_dzdx,
  input logic signed [RW-1:0] out_dzdy,
  input logic                 mul_start,
  input logic                 mul_busy,
  input logic                 div_start,
  input logic                 div_busy
);

  // R1: acceptance drops ready on the next cycle
  a_r1_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R1: ready returns right after the result strobe
  a_r1_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> in_ready);

  // R1: ready is still low while the result is shown
  a_r1_ready_low_at_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2: result strobe lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2: no result while an arithmetic unit is still working
  a_r2_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_busy || div_busy) |-> !out_valid);

  // R6: only one arithmetic unit runs at a time and none is restarted mid-run
  a_r6_mul_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    mul_start |-> (!mul_busy && !div_busy));

  a_r6_div_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    div_start |-> (!div_busy && !mul_busy));

  // R8: degenerate triangles report flat depth
  a_r8_degen_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_degen) |-> (out_dzdx == '0 && out_dzdy == '0));

  // R10: reset state
  always_comb begin
    if (!rst_n) begin
      a_r10_reset_idle: assert (in_ready && !out_valid);
    end
  end

endmodule

bind tri_setup tri_setup_chk #(.RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_degen (out_degen),
  .out_dzdx  (out_dzdx),
  .out_dzdy  (out_dzdy),
  .mul_start (mul_start),
  .mul_busy  (mul_busy),
  .div_start (div_start),
  .div_busy  (div_busy)
);

// File: tb/tri_setup_tb.sv
`timescale 1ns/1ps
module tri_setup_tb;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [2:0][9:0]   vx = '0;
  logic [2:0][8:0]   vy = '0;
  logic [2:0][15:0]  vz = '0;
  logic [7:0]        color = '0;
  logic [5:0]        tile_x = '0;
  logic [4:0]        tile_y = '0;
  logic              out_valid;
  logic [2:0][31:0]  out_edge;
  logic [2:0][11:0]  out_dedx;
  logic [2:0][11:0]  out_dedy;
  logic signed [31:0] out_z, out_dzdx, out_dzdy;
  logic [7:0]        out_color;
  logic              out_degen;

  always #2.5 clk = ~clk;

  tri_setup u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .vx(vx), .vy(vy), .vz(vz), .color(color), .tile_x(tile_x), .tile_y(tile_y),
    .out_valid(out_valid), .out_edge(out_edge), .out_dedx(out_dedx), .out_dedy(out_dedy),
    .out_z(out_z), .out_dzdx(out_dzdx), .out_dzdy(out_dzdy),
    .out_color(out_color), .out_degen(out_degen)
  );

  int n_chk = 0;
  int n_bad = 0;
  int px[3], py[3], pz[3];
  int unsigned seed = 32'h1234_5678;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int unsigned nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic run_tri(input int col, input int tlx, input int tly);
    int tx, ty, j, area, nzx, nzy, sx, sy, wait_n;
    int e_exp[3];
    longint zl;
    tx = tlx * 16;
    ty = tly * 16;
    for (int i = 0; i < 3; i++) begin
      j = (i + 1) % 3;
      e_exp[i] = (tx - px[i]) * (py[j] - py[i]) - (ty - py[i]) * (px[j] - px[i]);
    end
    area = (px[1] - px[0]) * (py[2] - py[0]) - (px[2] - px[0]) * (py[1] - py[0]);
    nzx  = (pz[1] - pz[0]) * (py[2] - py[0]) - (pz[2] - pz[0]) * (py[1] - py[0]);
    nzy  = (pz[2] - pz[0]) * (px[1] - px[0]) - (pz[1] - pz[0]) * (px[2] - px[0]);
    sx = (area != 0) ? nzx / area : 0;
    sy = (area != 0) ? nzy / area : 0;
    zl = longint'(pz[0]) + longint'(sx) * (tx - px[0]) + longint'(sy) * (ty - py[0]);

    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      vx[i] = px[i][9:0];
      vy[i] = py[i][8:0];
      vz[i] = pz[i][15:0];
    end
    color  = col[7:0];
    tile_x = tlx[5:0];
    tile_y = tly[4:0];
    in_valid = 1'b1;
    chk("R1 ready before accept", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    // R9: scramble inputs while busy
    vx = ~vx; vy = ~vy; vz = ~vz; color = ~color; tile_x = ~tile_x; tile_y = ~tile_y;
    chk("R1 ready low after accept", in_ready, 0);
    wait_n = 0;
    while (!out_valid && wait_n < 3000) begin
      @(negedge clk);
      wait_n++;
    end
    chk("R2 result strobe seen", out_valid, 1);
    chk("R1 ready low with result", in_ready, 0);
    for (int i = 0; i < 3; i++) begin
      j = (i + 1) % 3;
      chk($sformatf("R3 edge%0d", i), int'($signed(out_edge[i])), e_exp[i]);
      chk($sformatf("R4 dedx%0d", i), int'($signed(out_dedx[i])), py[j] - py[i]);
      chk($sformatf("R4 dedy%0d", i), int'($signed(out_dedy[i])), px[i] - px[j]);
    end
    chk("R5 degenerate flag", out_degen, (area == 0) ? 1 : 0);
    chk("R6 dzdx", out_dzdx, sx);
    chk("R6 dzdy", out_dzdy, sy);
    chk("R7 z origin", out_z, int'(zl[31:0]));
    if (area == 0) chk("R8 degenerate z", out_z, pz[0]);
    chk("R9 color", out_color, col & 255);
    @(negedge clk);
    chk("R2 strobe one cycle", out_valid, 0);
    chk("R1 ready back", in_ready, 1);
  endtask

  task automatic set_v(input int i, input int x, input int y, input int z);
    px[i] = x; py[i] = y; pz[i] = z;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ready in reset", in_ready, 1);
    chk("R10 no result in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", in_ready, 1);
    chk("R10 valid after reset", out_valid, 0);

    // directed: simple triangle, both windings
    set_v(0, 10, 10, 256); set_v(1, 40, 12, 1024); set_v(2, 20, 35, -512);
    run_tri(8'h5A, 0, 0);
    set_v(0, 10, 10, 256); set_v(1, 20, 35, -512); set_v(2, 40, 12, 1024);
    run_tri(8'hA5, 1, 1);
    // corner coordinates and the far tile
    set_v(0, 639, 479, 32767); set_v(1, 0, 479, -32768); set_v(2, 639, 0, 0);
    run_tri(8'hFF, 39, 29);
    run_tri(8'h00, 0, 0);
    // R8: collinear and coincident vertices on several tiles
    set_v(0, 0, 0, 100); set_v(1, 10, 10, 5000); set_v(2, 20, 20, -7000);
    run_tri(8'h11, 3, 4);
    set_v(0, 300, 200, -1234); set_v(1, 300, 200, 999); set_v(2, 300, 200, 77);
    run_tri(8'h22, 18, 12);
    set_v(0, 5, 400, 4000); set_v(1, 600, 400, -4000); set_v(2, 100, 400, 1);
    run_tri(8'h33, 39, 0);
    // sign: tiny area, large depth difference
    set_v(0, 100, 100, -32768); set_v(1, 101, 100, 32767); set_v(2, 100, 101, 0);
    run_tri(8'h44, 20, 20);

    // sweep every tile column, row tied to the column
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < 3; i++)
        set_v(i, int'(nxt() % 640), int'(nxt() % 480), int'(nxt() % 65536) - 32768);
      run_tri(t * 7, t, t % 30);
    end
    // sweep random triangles over a grid of tiles
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 3; b++) begin
        for (int k = 0; k < 8; k++) begin
          for (int i = 0; i < 3; i++)
            set_v(i, int'(nxt() % 640), int'(nxt() % 480), int'(nxt() % 65536) - 32768);
          run_tri(a * 31 + k, a * 13, b * 14);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule